// File: doc/BRIEF.md
# Multi-mode cartridge bank mapper

This block sits between a console's CPU and PPU buses and the ROM of a multi-game cartridge. It turns the address being fetched into an extended bank number. A mode byte, which the CPU writes into a small decode window, picks one of four layouts. The flat layout maps one 32 KB program image and one 8 KB pattern image. The fixed layout has a hard-wired set of 8 KB program banks and one swappable slot. Two banked windows take the bank numbers that an embedded scanline-style bank-register file produces, then mask and offset them into a 128 KB or a 256 KB region of the ROM.

The outputs are purely combinational from the stored registers and the present addresses. The program output counts in 8 KB units and the pattern output counts in 1 KB units. The block also flags accesses that should go to 8 KB of work RAM. It forwards a write strobe to the embedded register file when a banked layout is active. The ROM, the interrupt timers and the embedded register file lie outside this block.

Top module: `multimode_bank_mapper`

## Requirements
- R1: After a synchronous active-low reset the mode is flat 0x00 and the swappable fixed-layout bank register is 0. With flat 0x00, a CPU address at or above 0x8000 gives a program bank equal to address bits 14:13, and the pattern bank equals PPU address bits 12:10.
- R2: The mode register is loaded on `cpu_wr` only when the address lies in 0x4000–0x4FFF and has bit 8 set (for example 0x4100 or 0x4FFF). Writes to any other address, such as 0x4000, 0x5100 or 0x8000, leave the mode unchanged.
- R3: Flat modes use codes 0x00 and 0x01. For CPU addresses at or above 0x8000 the program bank is {code bit 0, address bits 14:13}. The pattern bank is {code & 3, PPU bits 12:10}, so it is 0–7 or 8–15.
- R4: Fixed mode uses code 0x13. The 8 KB program bank for each CPU address range is as follows: 0x6000–0x7FFF gives 14, 0x8000–0x9FFF gives 12, 0xA000–0xBFFF gives 13, 0xC000–0xDFFF gives 8 plus the bank register, and 0xE000–0xFFFF gives 15. The pattern bank is {3, PPU bits 12:10}, so it is 24–31.
- R5: In fixed mode a write to 0xE000–0xFFFF loads the 3-bit bank register from data bits 2:0. In any other mode such writes leave the bank register unchanged, and the old value shows again once fixed mode returns.
- R6: The 128 KB window uses code 0x37. For CPU addresses at or above 0x8000 the program bank is 16 + (inner program bank & 15). The pattern bank is 128 + (inner pattern bank & 127).
- R7: The 256 KB window uses code 0xFF. For CPU addresses at or above 0x8000 the program bank is 32 + (inner program bank & 31). The pattern bank is 256 + inner pattern bank.
- R8: A mode write whose data is not one of 0x00, 0x01, 0x13, 0x37 or 0xFF leaves the previous mode in force.
- R9: `inner_wr` is high in the same cycle as `cpu_wr` when a banked window mode is active and the address lies in 0x8000–0xBFFF. In every other case it is low.
- R10: `wram_sel` is high only in a banked window mode with a CPU address in 0x6000–0x7FFF. Outside the address ranges named in R1, R3, R4, R6 and R7 the program bank output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| inner_prg_bank | input | 8 | 8 KB program bank from the embedded register file for the current CPU address |
| inner_chr_bank | input | 8 | 1 KB pattern bank from the embedded register file for the current PPU address |
| ppu_addr_hi | input | 3 | PPU address bits 12:10 |
| prg_bank | output | 6 | Extended 8 KB program bank |
| chr_bank | output | 9 | Extended 1 KB pattern bank |
| wram_sel | output | 1 | Current CPU access targets work RAM |
| inner_wr | output | 1 | Write strobe forwarded to the embedded register file |

## Verification
The bench builds the block with its default widths: 8-bit inner bank numbers, a 6-bit program output, a 9-bit pattern output and a 3-bit fixed-layout register. At these widths the 256 KB window drives the top program bit and pattern bit 8. Inner values with high bits set then show that the 128 KB window masks those bits away. The full 3-bit register range reaches program banks 8 to 15 in the fixed layout. A behavioural model tracks the mode byte and the register across valid, invalid and misplaced writes, and across a reset in the middle of the run.

// File: rtl/bank_mapper_pkg.sv
// Shared mode encoding and decode helpers for the multi-mode bank mapper.
// Assumes the mode byte values are fixed by the cartridge software.
package bank_mapper_pkg;

    typedef enum logic [2:0] {
        MK_FLAT0  = 3'd0,
        MK_FLAT1  = 3'd1,
        MK_FIXED  = 3'd2,
        MK_WIN128 = 3'd3,
        MK_WIN256 = 3'd4
    } mode_kind_t;

    localparam logic [7:0] CODE_FLAT0  = 8'h00;
    localparam logic [7:0] CODE_FLAT1  = 8'h01;
    localparam logic [7:0] CODE_FIXED  = 8'h13;
    localparam logic [7:0] CODE_WIN128 = 8'h37;
    localparam logic [7:0] CODE_WIN256 = 8'hFF;

    // True when the byte names one of the supported layouts.
    function automatic logic code_valid(input logic [7:0] c);
        return (c == CODE_FLAT0) || (c == CODE_FLAT1) || (c == CODE_FIXED) ||
               (c == CODE_WIN128) || (c == CODE_WIN256);
    endfunction

    // Map a valid byte to its layout kind.
    function automatic mode_kind_t code_to_kind(input logic [7:0] c);
        case (c)
            CODE_FLAT1:  return MK_FLAT1;
            CODE_FIXED:  return MK_FIXED;
            CODE_WIN128: return MK_WIN128;
            CODE_WIN256: return MK_WIN256;
            default:     return MK_FLAT0;
        endcase
    endfunction

    // True for the two layouts fed by the embedded register file.
    function automatic logic is_banked(input mode_kind_t m);
        return (m == MK_WIN128) || (m == MK_WIN256);
    endfunction

endpackage

// File: rtl/bank_mapper_mode_reg.sv
// Holds the layout kind and the fixed-layout swappable bank register.
// Assumes the write qualifiers arrive already decoded from the address.
module bank_mapper_mode_reg
    import bank_mapper_pkg::*;
#(
    parameter int FIX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             fix_wr,
    input  logic [7:0]       wr_data,
    output mode_kind_t       mode,
    output logic [FIX_W-1:0] fix_reg
);

    // Load the mode on a valid code; unknown codes keep the current layout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MK_FLAT0;
        else if (mode_wr && code_valid(wr_data))
            mode <= code_to_kind(wr_data);
    end

    // Load the swappable fixed-layout bank from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fix_reg <= '0;
        else if (fix_wr)
            fix_reg <= wr_data[FIX_W-1:0];
    end

endmodule

// File: rtl/bank_mapper_prg_xlate.sv
// Turns the CPU address window and the inner bank into an extended 8 KB
// program bank, and flags work-RAM accesses. Assumes INNER_W >= 8.
module bank_mapper_prg_xlate
    import bank_mapper_pkg::*;
#(
    parameter int INNER_W = 8,
    parameter int PRG_W   = 6,
    parameter int FIX_W   = 3
) (
    input  mode_kind_t         mode,
    input  logic [FIX_W-1:0]   fix_reg,
    input  logic [2:0]         addr_hi,
    input  logic [INNER_W-1:0] inner_prg,
    output logic [PRG_W-1:0]   prg_bank,
    output logic               wram_sel
);

    localparam int SLOT_W = 8;

    logic unused_inner_bits;
    assign unused_inner_bits = ^inner_prg[INNER_W-1:5];

    // Select the program bank for the current 8 KB CPU slot.
    always_comb begin
        prg_bank = '0;
        unique case (mode)
            MK_FLAT0, MK_FLAT1: begin
                if (addr_hi[2])
                    prg_bank = PRG_W'({mode == MK_FLAT1, addr_hi[1:0]});
            end
            MK_FIXED: begin
                case (addr_hi)
                    3'd3:    prg_bank = PRG_W'(8'h0E);
                    3'd4:    prg_bank = PRG_W'(8'h0C);
                    3'd5:    prg_bank = PRG_W'(8'h0D);
                    3'd6:    prg_bank = PRG_W'(8'h08 | SLOT_W'(fix_reg));
                    3'd7:    prg_bank = PRG_W'(8'h0F);
                    default: prg_bank = '0;
                endcase
            end
            MK_WIN128: begin
                if (addr_hi[2])
                    prg_bank = PRG_W'({2'b01, inner_prg[3:0]});
            end
            MK_WIN256: begin
                if (addr_hi[2])
                    prg_bank = PRG_W'({1'b1, inner_prg[4:0]});
            end
            default: prg_bank = '0;
        endcase
    end

    // Work RAM answers in the 0x6000 slot of the banked layouts.
    always_comb wram_sel = is_banked(mode) && (addr_hi == 3'b011);

endmodule

// File: rtl/bank_mapper_chr_xlate.sv
// Turns the PPU address and the inner pattern bank into an extended 1 KB
// pattern bank. Assumes INNER_W >= 8 and CHR_W >= 9.
module bank_mapper_chr_xlate
    import bank_mapper_pkg::*;
#(
    parameter int INNER_W = 8,
    parameter int CHR_W   = 9
) (
    input  mode_kind_t         mode,
    input  logic [2:0]         ppu_hi,
    input  logic [INNER_W-1:0] inner_chr,
    output logic [CHR_W-1:0]   chr_bank
);

    // Select the pattern bank for the current 1 KB PPU slot.
    always_comb begin
        unique case (mode)
            MK_FLAT0:  chr_bank = CHR_W'({2'b00, ppu_hi});
            MK_FLAT1:  chr_bank = CHR_W'({2'b01, ppu_hi});
            MK_FIXED:  chr_bank = CHR_W'({2'b11, ppu_hi});
            MK_WIN128: chr_bank = CHR_W'({2'b01, inner_chr[6:0]});
            MK_WIN256: chr_bank = CHR_W'({1'b1, inner_chr[7:0]});
            default:   chr_bank = '0;
        endcase
    end

endmodule

// File: rtl/multimode_bank_mapper.sv
// Top of the multi-mode bank mapper. It decodes CPU writes into the mode and
// fixed-bank registers and forwards banked-window writes to the embedded
// register file. Assumes cpu_wr lasts one cycle per bus write.
module multimode_bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int INNER_W = 8,
    parameter int PRG_W   = 6,
    parameter int CHR_W   = 9,
    parameter int FIX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_data,
    input  logic [INNER_W-1:0] inner_prg_bank,
    input  logic [INNER_W-1:0] inner_chr_bank,
    input  logic [2:0]         ppu_addr_hi,
    output logic [PRG_W-1:0]   prg_bank,
    output logic [CHR_W-1:0]   chr_bank,
    output logic               wram_sel,
    output logic               inner_wr
);

    mode_kind_t       mode;
    logic [FIX_W-1:0] fix_reg;
    logic             mode_hit;
    logic             mode_wr;
    logic             fix_wr;
    logic             unused_addr_bits;

    assign unused_addr_bits = ^{cpu_addr[11:9], cpu_addr[7:0]};

    // Mode window: 0x4000-0x4FFF with address bit 8 set.
    always_comb mode_hit = (cpu_addr[15:12] == 4'h4) && cpu_addr[8];
    always_comb mode_wr  = cpu_wr && mode_hit;
    // Fixed-layout bank writes land in the top 8 KB slot.
    always_comb fix_wr   = cpu_wr && (cpu_addr[15:13] == 3'b111) && (mode == MK_FIXED);
    // Forward 0x8000-0xBFFF writes to the embedded file in banked layouts.
    always_comb inner_wr = cpu_wr && is_banked(mode) && (cpu_addr[15:14] == 2'b10);

    bank_mapper_mode_reg #(.FIX_W(FIX_W)) u_mode_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .fix_wr  (fix_wr),
        .wr_data (cpu_data),
        .mode    (mode),
        .fix_reg (fix_reg)
    );

    bank_mapper_prg_xlate #(.INNER_W(INNER_W), .PRG_W(PRG_W), .FIX_W(FIX_W)) u_prg (
        .mode      (mode),
        .fix_reg   (fix_reg),
        .addr_hi   (cpu_addr[15:13]),
        .inner_prg (inner_prg_bank),
        .prg_bank  (prg_bank),
        .wram_sel  (wram_sel)
    );

    bank_mapper_chr_xlate #(.INNER_W(INNER_W), .CHR_W(CHR_W)) u_chr (
        .mode      (mode),
        .ppu_hi    (ppu_addr_hi),
        .inner_chr (inner_chr_bank),
        .chr_bank  (chr_bank)
    );

    // R2
    mode_nonwindow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !((cpu_addr[15:12] == 4'h4) && cpu_addr[8])) |=> $stable(mode));

    // R8
    mode_badcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !code_valid(cpu_data)) |=> $stable(mode));

    // R5
    fix_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && (cpu_addr[15:13] == 3'b111) && (mode == MK_FIXED)) |=> $stable(fix_reg));

    // R9
    inner_wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inner_wr |-> (cpu_wr && cpu_addr[15] && !cpu_addr[14]));

    // R10
    wram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wram_sel |-> (cpu_addr[15:13] == 3'b011));

    // R6
    win128_prg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MK_WIN128) && cpu_addr[15]) |-> ((prg_bank >= PRG_W'(16)) && (prg_bank < PRG_W'(32))));

    // R7
    win256_chr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MK_WIN256) |-> (chr_bank >= CHR_W'(256)));

endmodule

// File: tb/multimode_bank_mapper_bench.sv
`timescale 1ns/1ps
module multimode_bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_wr;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic [7:0]  inner_prg_bank;
    logic [7:0]  inner_chr_bank;
    logic [2:0]  ppu_addr_hi;
    logic [5:0]  prg_bank;
    logic [8:0]  chr_bank;
    logic        wram_sel;
    logic        inner_wr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference state
    int m_mode = 0;
    int m_reg  = 0;

    always #4 clk = ~clk;

    multimode_bank_mapper u_multimode_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .inner_prg_bank(inner_prg_bank),
        .inner_chr_bank(inner_chr_bank), .ppu_addr_hi(ppu_addr_hi),
        .prg_bank(prg_bank), .chr_bank(chr_bank), .wram_sel(wram_sel),
        .inner_wr(inner_wr)
    );

    function automatic int exp_prg(int a, int inner);
        if (a >= 'h8000) begin
            case (m_mode)
                'h00, 'h01: return (m_mode & 1) * 4 + ((a >> 13) & 3);
                'h13: begin
                    if (a < 'hA000) return 'h0C;
                    if (a < 'hC000) return 'h0D;
                    if (a < 'hE000) return 8 + m_reg;
                    return 'h0F;
                end
                'h37: return 16 + (inner & 15);
                default: return 32 + (inner & 31);
            endcase
        end
        if (m_mode == 'h13 && a >= 'h6000) return 'h0E;
        return 0;
    endfunction

    function automatic int exp_chr(int p, int inner);
        case (m_mode)
            'h00, 'h01, 'h13: return (m_mode & 3) * 8 + p;
            'h37: return 128 + (inner & 127);
            default: return 256 + inner;
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One bus cycle: drive, compare against the model, then advance the model.
    task automatic step(string tag, bit rst, bit wr, int a, int d, int ip, int ic, int p);
        int banked;
        @(negedge clk);
        rst_n = ~rst; cpu_wr = wr; cpu_addr = 16'(a); cpu_data = 8'(d);
        inner_prg_bank = 8'(ip); inner_chr_bank = 8'(ic); ppu_addr_hi = 3'(p);
        #2;
        if (!rst) begin
            banked = (m_mode == 'h37 || m_mode == 'hFF);
            check(tag, "prg_bank", int'(prg_bank), exp_prg(a, ip));
            check(tag, "chr_bank", int'(chr_bank), exp_chr(p, ic));
            check(tag, "wram_sel", int'(wram_sel), int'(banked && a >= 'h6000 && a < 'h8000));
            check(tag, "inner_wr", int'(inner_wr), int'(wr && banked && a >= 'h8000 && a < 'hC000));
        end
        @(posedge clk);
        if (rst) begin
            m_mode = 0; m_reg = 0;
        end else if (wr) begin
            if (m_mode == 'h13 && a >= 'hE000) m_reg = d & 7;
            if (a >= 'h4000 && a < 'h5000 && (a & 'h100) != 0 &&
                (d == 'h00 || d == 'h01 || d == 'h13 || d == 'h37 || d == 'hFF))
                m_mode = d;
        end
    endtask

    task automatic sweep(string tag, int seed);
        int addrs[8] = '{'h5000, 'h6000, 'h7FFF, 'h8000, 'hA001, 'hC000, 'hE000, 'hFFFF};
        for (int i = 0; i < 8; i++)
            step(tag, 0, 0, addrs[i], 0, (seed * 37 + i * 29) & 255, (seed * 53 + i * 71) & 255, i);
    endtask

    initial begin
        rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_data = '0;
        inner_prg_bank = '0; inner_chr_bank = '0; ppu_addr_hi = '0;
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 1, 'h4100, 'h13, 0, 0, 0);
        sweep("R1", 1);
        // R2: misplaced mode writes
        step("R2", 0, 1, 'h4000, 'h01, 0, 0, 0);
        step("R2", 0, 1, 'h5100, 'h13, 0, 0, 0);
        step("R2", 0, 1, 'h8000, 'h37, 0, 0, 0);
        step("R2", 0, 1, 'h6100, 'hFF, 0, 0, 0);
        sweep("R2", 2);
        // R3: flat 1
        step("R3", 0, 1, 'h4100, 'h01, 0, 0, 0);
        sweep("R3", 3);
        // R4: fixed layout through the top of the window
        step("R4", 0, 1, 'h4FFF, 'h13, 0, 0, 0);
        sweep("R4", 4);
        // R5: bank register loads
        step("R5", 0, 1, 'hE000, 'h05, 0, 0, 0);
        step("R5", 0, 0, 'hC000, 0, 0, 0, 0);
        step("R5", 0, 1, 'hFFFF, 'hFA, 0, 0, 0);
        step("R5", 0, 0, 'hDFFF, 0, 0, 0, 0);
        // R9: no forwarding in fixed layout
        step("R9", 0, 1, 'h8000, 'h06, 0, 0, 0);
        // R8: bad codes keep fixed layout
        step("R8", 0, 1, 'h4100, 'h42, 0, 0, 0);
        step("R8", 0, 1, 'h4100, 'h14, 0, 0, 0);
        sweep("R8", 5);
        // R6: 128 KB window
        step("R6", 0, 1, 'h4100, 'h37, 0, 0, 0);
        sweep("R6", 6);
        step("R6", 0, 0, 'h9000, 0, 'hFF, 'hFF, 0);
        step("R10", 0, 0, 'h6800, 0, 'h0A, 'h0B, 2);
        step("R9", 0, 1, 'h8001, 'h46, 1, 2, 3);
        step("R9", 0, 1, 'hA000, 'h80, 1, 2, 3);
        step("R9", 0, 1, 'hC000, 'h11, 1, 2, 3);
        step("R5", 0, 1, 'hE000, 'h07, 0, 0, 0);
        // R7: 256 KB window
        step("R7", 0, 1, 'h4100, 'hFF, 0, 0, 0);
        sweep("R7", 7);
        step("R7", 0, 0, 'hFFFF, 0, 'hFF, 'hFF, 7);
        step("R8", 0, 1, 'h4100, 'h80, 0, 0, 0);
        step("R8", 0, 0, 'hB000, 0, 'h3C, 'hC3, 1);
        step("R10", 0, 0, 'h4000, 0, 'h3C, 'hC3, 1);
        // R5: register kept while away from fixed layout
        step("R5", 0, 1, 'h4100, 'h13, 0, 0, 0);
        step("R5", 0, 0, 'hC000, 0, 0, 0, 0);
        // R1: reset mid-run clears mode and register
        step("R1", 1, 0, 0, 0, 0, 0, 0);
        sweep("R1", 8);
        step("R1", 0, 1, 'h4100, 'h13, 0, 0, 0);
        step("R1", 0, 0, 'hC000, 0, 0, 0, 5);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule